// File: doc/BRIEF.md
# Staged LED Control Register Bank

This block keeps the configuration state of a multi-channel LED driver. A simple byte-wide write port (strobe, address, data) lands each write in one of several register groups. Per-channel brightness bytes and per-channel control fields (an enable bit and a two-bit current scale code) are first written into a shadow copy. They reach the outputs only when software issues a commit command, so that all channels can change together on one clock edge.

Two global bits act on the next clock edge without staging. One is a software run bit, where 0 means shutdown. The other is a force-all-dark bit, where 1 means every LED is blanked. A clear command returns the whole bank to its power-up defaults. Shutting the outputs down never alters stored values. A bus front end drives the write port, and a pulse-width generator consumes the outputs; neither is part of this block.

Top module: `led_regbank`

## Requirements
- R1: After reset, every brightness byte, enable bit, scale code, `sw_run_o` and `all_off_o` output is 0.
- R2: A write to address 01h+i (channel i, 0-based, 36 channels so 01h..24h) stores the byte in the shadow brightness register of channel i only. The outputs do not change.
- R3: Writing data 00h to address 25h copies every shadow brightness and control value to the outputs. All channels change together, visible one clock after the write.
- R4: A write to address 26h+i (26h..49h) stages a control field for channel i. Data bit 0 is the enable bit and data bits 2:1 are the scale code. Bits 7:3 are discarded, and the outputs change only on a commit.
- R5: A write to address 00h sets `sw_run_o` to data bit 0. A write to 4Ah sets `all_off_o` to data bit 0. Each takes effect one clock after the write, with no commit.
- R6: Writing data 00h to address 4Fh returns both shadow and active copies of every channel register, and both global bits, to 0.
- R7: A nonzero write to 25h or 4Fh has no effect. So has a write to any address outside 00h..4Ah other than 4Fh, or a cycle with the strobe low.
- R8: Changing `sw_run_o` or `all_off_o` leaves every stored brightness and control value unchanged. Shadow contents also survive a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| duty_o | output | 288 | Active brightness bytes, channel i at bits 8i+7..8i |
| led_on_o | output | 36 | Active enable bit per channel |
| scale_o | output | 72 | Active scale code, channel i at bits 2i+1..2i |
| sw_run_o | output | 1 | Software run bit (0 = shutdown) |
| all_off_o | output | 1 | Force-all-dark bit (1 = blank) |

## Verification
The bench writes shadow values and checks that the outputs hold their old values until a commit. A design that forwards writes straight through fails there. It sends nonzero data to the commit and clear addresses and writes the unmapped gap 4Bh..4Eh. It then issues a genuine commit so that a corrupted shadow copy becomes visible at the ports; a decoder that ignores the data value or aliases addresses fails this check. It also fills the control field's upper bits with ones, and it toggles the global bits while comparing every channel output, which catches field misplacement and shutdown logic that wipes stored data. A clear followed by a commit shows whether the shadow copy was really cleared.

// File: rtl/led_regbank_pkg.sv
package led_regbank_pkg;
    localparam int DUTY_W = 8;
    localparam int SCL_W  = 2;
    localparam int CTL_W  = SCL_W + 1;

    typedef struct packed {
        logic [DUTY_W-1:0] stg_duty;
        logic [CTL_W-1:0]  stg_ctl;
        logic [DUTY_W-1:0] act_duty;
        logic [CTL_W-1:0]  act_ctl;
    } chan_state_t;

    typedef struct packed {
        logic run;
        logic all_off;
    } glob_state_t;
endpackage

// File: rtl/led_regbank_decode.sv
module led_regbank_decode #(
    parameter int NUM_CH   = 36,
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int PWM_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NUM_CH-1:0] duty_hit,
    output logic [NUM_CH-1:0] ctl_hit,
    output logic              commit,
    output logic              clear,
    output logic              run_we,
    output logic              off_we
);
    localparam int RUN_ADDR = 0;
    localparam int UPD_ADDR = PWM_BASE + NUM_CH;
    localparam int CTL_BASE = UPD_ADDR + 1;
    localparam int OFF_ADDR = CTL_BASE + NUM_CH;
    localparam int CLR_ADDR = OFF_ADDR + 5;

    logic zero_data;
    int   a;

    always_comb begin
        a         = int'(wr_addr);
        zero_data = (wr_data == '0);
        duty_hit  = '0;
        ctl_hit   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            duty_hit[i] = wr_en && (a == PWM_BASE + i);
            ctl_hit[i]  = wr_en && (a == CTL_BASE + i);
        end
        commit = wr_en && (a == UPD_ADDR) && zero_data;
        clear  = wr_en && (a == CLR_ADDR) && zero_data;
        run_we = wr_en && (a == RUN_ADDR);
        off_we = wr_en && (a == OFF_ADDR);
    end

    // R7: at most one register action per write
    assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({duty_hit, ctl_hit, commit, clear, run_we, off_we}));

    // R7: no strobe, no action
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !(commit || clear || run_we || off_we || (|duty_hit) || (|ctl_hit)));
endmodule

// File: rtl/led_regbank_chan.sv
module led_regbank_chan
    import led_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duty_we,
    input  logic              ctl_we,
    input  logic              commit,
    input  logic              clear,
    input  logic [DUTY_W-1:0] wdata,
    output logic [DUTY_W-1:0] duty_o,
    output logic              on_o,
    output logic [SCL_W-1:0]  scale_o
);
    chan_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else begin
            if (duty_we) s_d.stg_duty = wdata;
            if (ctl_we)  s_d.stg_ctl  = wdata[CTL_W-1:0];
            if (commit) begin
                s_d.act_duty = s_q.stg_duty;
                s_d.act_ctl  = s_q.stg_ctl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign duty_o  = s_q.act_duty;
    assign on_o    = s_q.act_ctl[0];
    assign scale_o = s_q.act_ctl[CTL_W-1:1];

    // R2: active side moves only on commit or clear
    assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit || clear) |=> $stable(duty_o) && $stable(on_o) && $stable(scale_o));

    // R3: commit exposes the shadow value held before the edge
    assert_commit_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !clear) |=> (duty_o == $past(s_q.stg_duty)) && (on_o == $past(s_q.stg_ctl[0])));

    // R6: clear empties both copies
    assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q == '0));

    // R8: shadow survives commit
    assert_shadow_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !clear) |=> $stable(s_q.stg_duty) && $stable(s_q.stg_ctl));
endmodule

// File: rtl/led_regbank.sv
module led_regbank
    import led_regbank_pkg::*;
#(
    parameter int NUM_CH   = 36,
    parameter int AW       = 8,
    parameter int PWM_BASE = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DUTY_W-1:0]        wr_data,
    output logic [NUM_CH*DUTY_W-1:0] duty_o,
    output logic [NUM_CH-1:0]        led_on_o,
    output logic [NUM_CH*SCL_W-1:0]  scale_o,
    output logic                     sw_run_o,
    output logic                     all_off_o
);
    logic [NUM_CH-1:0] duty_hit, ctl_hit;
    logic commit, clear, run_we, off_we;

    led_regbank_decode #(
        .NUM_CH(NUM_CH), .AW(AW), .DW(DUTY_W), .PWM_BASE(PWM_BASE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .duty_hit(duty_hit), .ctl_hit(ctl_hit),
        .commit(commit), .clear(clear), .run_we(run_we), .off_we(off_we)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        led_regbank_chan u_ch (
            .clk(clk), .rst_n(rst_n),
            .duty_we(duty_hit[i]), .ctl_we(ctl_hit[i]),
            .commit(commit), .clear(clear), .wdata(wr_data),
            .duty_o(duty_o[i*DUTY_W +: DUTY_W]),
            .on_o(led_on_o[i]),
            .scale_o(scale_o[i*SCL_W +: SCL_W])
        );
    end

    glob_state_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (clear) begin
            g_d = '0;
        end else begin
            if (run_we) g_d.run     = wr_data[0];
            if (off_we) g_d.all_off = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign sw_run_o  = g_q.run;
    assign all_off_o = g_q.all_off;

    // R5: run bit follows data bit 0 of a write to address 00h
    assert_run_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> sw_run_o == $past(wr_data[0]));

    // R7: global bits keep value with no strobe
    assert_glob_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sw_run_o) && $stable(all_off_o));
endmodule

// File: tb/led_regbank_tb.sv
`timescale 1ns/1ps
module led_regbank_tb;
    localparam int N = 36;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic [N*8-1:0] duty_o;
    logic [N-1:0]   led_on_o;
    logic [N*2-1:0] scale_o;
    logic sw_run_o, all_off_o;

    int total = 0, bad = 0;
    bit done = 0;

    logic [7:0] m_sd [N];
    logic [7:0] m_ad [N];
    logic [2:0] m_sc [N];
    logic [2:0] m_ac [N];
    logic m_run, m_off;

    always #2 clk = ~clk;

    led_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .duty_o(duty_o), .led_on_o(led_on_o),
        .scale_o(scale_o), .sw_run_o(sw_run_o), .all_off_o(all_off_o)
    );

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_sd[i] = 0; m_ad[i] = 0; m_sc[i] = 0; m_ac[i] = 0;
        end
        m_run = 0; m_off = 0;
    endtask

    // register map from the requirements: 00h run, 01h+i duty, 25h commit,
    // 26h+i control, 4Ah all-off, 4Fh clear
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (a == 8'h00) m_run = d[0];
        else if (a >= 8'h01 && a <= 8'h24) m_sd[a-8'h01] = d;
        else if (a == 8'h25 && d == 0) begin
            for (int i = 0; i < N; i++) begin m_ad[i] = m_sd[i]; m_ac[i] = m_sc[i]; end
        end
        else if (a >= 8'h26 && a <= 8'h49) m_sc[a-8'h26] = d[2:0];
        else if (a == 8'h4A) m_off = d[0];
        else if (a == 8'h4F && d == 0) model_clear();
    endtask

    task automatic check(input string req);
        logic [N*8-1:0] ed;
        logic [N-1:0]   eo;
        logic [N*2-1:0] es;
        for (int i = 0; i < N; i++) begin
            ed[i*8 +: 8] = m_ad[i];
            eo[i]        = m_ac[i][0];
            es[i*2 +: 2] = m_ac[i][2:1];
        end
        total++;
        if (duty_o !== ed) begin bad++; $display("FAIL %s duty act=%h exp=%h", req, duty_o, ed); end
        total++;
        if (led_on_o !== eo || scale_o !== es) begin
            bad++; $display("FAIL %s ctl act=%h/%h exp=%h/%h", req, led_on_o, scale_o, eo, es);
        end
        total++;
        if (sw_run_o !== m_run || all_off_o !== m_off) begin
            bad++; $display("FAIL %s glob act=%b%b exp=%b%b", req, sw_run_o, all_off_o, m_run, m_off);
        end
    endtask

    task automatic t_reset_r1();
        check("R1 reset");
    endtask

    task automatic t_stage_r2_r3();
        for (int i = 0; i < N; i++) wr(8'h01 + 8'(i), 8'(8'hA5 ^ (i*7)));
        check("R2 staged not visible");
        wr(8'h25, 8'h00);
        check("R3 commit all");
        wr(8'h01 + 8'd35, 8'hFF);
        wr(8'h01, 8'h00);
        check("R2 second stage held");
        wr(8'h25, 8'h00);
        check("R3 second commit");
    endtask

    task automatic t_ctl_r4();
        for (int i = 0; i < N; i++) wr(8'h26 + 8'(i), 8'hF8 | 8'(i % 8));
        check("R4 ctl staged");
        wr(8'h25, 8'h00);
        check("R4 ctl fields");
    endtask

    task automatic t_direct_r5_r8();
        wr(8'h00, 8'hFF); check("R5 run set");
        wr(8'h4A, 8'h01); check("R5 off set");
        wr(8'h00, 8'hFE); check("R8 run cleared keeps data");
        wr(8'h4A, 8'h00); check("R8 off cleared keeps data");
        wr(8'h25, 8'h00); check("R8 shadow kept after commit");
    endtask

    task automatic t_ignored_r7();
        wr(8'h00, 8'h01);
        wr(8'h05, 8'h3C);
        wr(8'h2A, 8'h07);
        wr(8'h25, 8'h01); check("R7 nonzero commit ignored");
        wr(8'h4F, 8'h80); check("R7 nonzero clear ignored");
        for (int a = 8'h4B; a <= 8'h4E; a++) wr(8'(a), 8'h00);
        wr(8'h60, 8'h00); wr(8'hFF, 8'h00);
        check("R7 unmapped ignored");
        @(negedge clk); wr_addr = 8'h4F; wr_data = 8'h00;
        @(negedge clk); check("R7 no strobe");
        wr(8'h25, 8'h00); check("R7 shadow intact after ignored writes");
    endtask

    task automatic t_clear_r6();
        wr(8'h10, 8'h99);
        wr(8'h4F, 8'h00); check("R6 clear");
        wr(8'h25, 8'h00); check("R6 shadow cleared");
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_r1();
        t_stage_r2_r3();
        t_ctl_r4();
        t_direct_r5_r8();
        t_ignored_r7();
        t_clear_r6();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule